// File: doc/BRIEF.md
# Adaptive per-block read-retry controller

This controller sits between a page-read request source and a flash read engine. It holds a small table with two learned reference codes per erase block. One code is for the boundary between the first and second programmed states, used by low-bit page reads. The other is for the boundary between the second and third programmed states, used by high-bit page reads. All pages of a block share that block's entry, because charge loss in one block progresses at a similar rate.

A read begins at the block's stored code for the page type and goes to the engine. The engine later returns a one-cycle ECC verdict. On each failure the code drops by a fixed step and the read is issued again. The step for the upper boundary is separate from the step for the lower boundary. The code never rises within a sequence, because the best reference only falls as data ages. The sequence ends on the first correctable read, at a retry limit, or when the next step would pass below a floor. A passing code is written back, so the next read of that block starts closer to the optimum. A relearn request resets a block to the top code, giving a fresh upper bound. The number of retries is reported with each result, and read latency grows linearly with it.

Top module: `rretry_ctrl`

## Requirements
- R1: After reset every table code is 255 (all ones), `req_ready` is 1, and both `rd_valid` and `done_valid` are 0.
- R2: An accepted read with `req_relearn`=0 presents on `rd_code` the block's stored code for the page type. `req_msb`=0 selects the low-boundary code and `req_msb`=1 selects the high-boundary code.
- R3: On each ECC failure that does not end the sequence, the next read carries the previous code minus the page type's step. That step is `cfg_step_lo` for `req_msb`=0 and `cfg_step_hi` for `req_msb`=1. The code never increases within a sequence.
- R4: The first passing ECC verdict ends the sequence with a one-cycle `done_valid`, `done_status`=0 (success) and `done_retries` equal to the number of failed reads before it.
- R5: On success the passing code replaces the block's entry for that page type. The other page type's entry and other blocks' entries stay as they were.
- R6: On a failure where the code is below the step, or the code minus the step is below `cfg_floor`, the sequence ends with `done_status`=1 (floor) and the entry is unchanged.
- R7: On a failure where the retry count already equals `cfg_max_retry`, the sequence ends with `done_status`=2 (limit) and the entry is unchanged. This limit check takes priority over the floor check.
- R8: A request with `req_relearn`=1 sets both codes of the block to 255. It issues no read and gives no `done_valid`.
- R9: `req_ready` is 1 only when no sequence is running. `rd_valid` stays high with a stable `rd_code` until `rd_ready`. An `ecc_valid` pulse while no verdict is awaited is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted |
| req_block | input | BW | Erase block index, BW = clog2(DEPTH) |
| req_msb | input | 1 | Page type: 0 low-bit page, 1 high-bit page |
| req_relearn | input | 1 | 1: relearn the block instead of reading |
| cfg_step_lo | input | CW | Decrement for the low-boundary code |
| cfg_step_hi | input | CW | Decrement for the high-boundary code |
| cfg_floor | input | CW | Lowest code a retry may use |
| cfg_max_retry | input | RC_W | Maximum retries per read |
| rd_valid | output | 1 | Read command to the engine |
| rd_ready | input | 1 | Engine takes the command |
| rd_code | output | CW | Reference code for the command |
| rd_msb | output | 1 | Page type of the command |
| ecc_valid | input | 1 | One-cycle ECC verdict pulse |
| ecc_pass | input | 1 | Verdict: 1 correctable |
| done_valid | output | 1 | One-cycle result pulse |
| done_status | output | 2 | 0 success, 1 floor, 2 limit |
| done_retries | output | RC_W | Retries in the finished sequence |

## Verification
The bench builds the controller with DEPTH=8 and RC_W=3. The small table lets blocks 0 to 4 be exercised and cross-checked for independence. The 3-bit retry counter lets a limit of 2 or 3 be reached after only a few reads. With 8-bit codes and steps of 4, 10 and 100, the floor is reached both by an ordinary floor crossing and by a step larger than the remaining code. The same retry count that meets the floor also meets the limit, which exposes the priority between the two checks.

// File: rtl/rretry_pkg.sv
package rretry_pkg;
  typedef enum logic [1:0] {
    RR_OK    = 2'd0,
    RR_FLOOR = 2'd1,
    RR_LIMIT = 2'd2
  } rr_status_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2
  } rr_state_e;
endpackage

// File: rtl/rretry_table.sv
module rretry_table #(
  parameter int DEPTH = 64,
  parameter int CW    = 8,
  parameter int BW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] rd_blk,
  input  logic          rd_sel,
  output logic [CW-1:0] rd_code,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_blk,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_code,
  input  logic          rl_en,
  input  logic [BW-1:0] rl_blk
);
  logic [CW-1:0] lo_q [DEPTH];
  logic [CW-1:0] hi_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic rl_hit, wr_hit;
    assign rl_hit = rl_en && (rl_blk == BW'(g));
    assign wr_hit = wr_en && (wr_blk == BW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[g] <= '1;
        hi_q[g] <= '1;
      end else begin
        if (rl_hit) begin
          lo_q[g] <= '1;
          hi_q[g] <= '1;
        end else if (wr_hit) begin
          if (wr_sel) hi_q[g] <= wr_code;
          else        lo_q[g] <= wr_code;
        end
      end
    end
  end

  assign rd_code = rd_sel ? hi_q[rd_blk] : lo_q[rd_blk];

  // R8: relearn and write-back never collide
  p_no_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rl_en && wr_en));

  // R8: a relearned block holds the top code in both fields
  p_relearn_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rl_en |=> (lo_q[$past(rl_blk)] == '1) && (hi_q[$past(rl_blk)] == '1));
endmodule

// File: rtl/rretry_step.sv
module rretry_step #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] code,
  input  logic [CW-1:0] step,
  input  logic [CW-1:0] floor_code,
  output logic [CW-1:0] nxt_code,
  output logic          below
);
  always_comb begin
    nxt_code = code - step;
    below    = (code < step) || (nxt_code < floor_code);
  end
endmodule

// File: rtl/rretry_fsm.sv
module rretry_fsm
  import rretry_pkg::*;
#(
  parameter int CW   = 8,
  parameter int RC_W = 4,
  parameter int BW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [BW-1:0]   req_block,
  input  logic            req_msb,
  input  logic            req_relearn,
  output logic            req_ready,
  input  logic [CW-1:0]   tbl_code,
  output logic            tbl_wr_en,
  output logic            tbl_rl_en,
  output logic [BW-1:0]   blk_q,
  output logic            msb_q,
  output logic [CW-1:0]   code_q,
  input  logic [CW-1:0]   nxt_code,
  input  logic            below,
  input  logic [RC_W-1:0] cfg_max_retry,
  output logic            rd_valid,
  input  logic            rd_ready,
  input  logic            ecc_valid,
  input  logic            ecc_pass,
  output logic            done_valid,
  output logic [1:0]      done_status,
  output logic [RC_W-1:0] done_retries
);
  rr_state_e       state_q, state_d;
  logic [CW-1:0]   code_d;
  logic [RC_W-1:0] retries_q, retries_d;
  logic            load_en;
  logic            dv_d;
  rr_status_e      ds_q, ds_d;

  always_comb begin
    state_d   = state_q;
    code_d    = code_q;
    retries_d = retries_q;
    load_en   = 1'b0;
    tbl_wr_en = 1'b0;
    tbl_rl_en = 1'b0;
    dv_d      = 1'b0;
    ds_d      = RR_OK;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          if (req_relearn) begin
            tbl_rl_en = 1'b1;
          end else begin
            load_en   = 1'b1;
            code_d    = tbl_code;
            retries_d = '0;
            state_d   = S_ISSUE;
          end
        end
      end
      S_ISSUE: begin
        if (rd_ready) state_d = S_WAIT;
      end
      S_WAIT: begin
        if (ecc_valid) begin
          if (ecc_pass) begin
            tbl_wr_en = 1'b1;
            dv_d      = 1'b1;
            ds_d      = RR_OK;
            state_d   = S_IDLE;
          end else if (retries_q == cfg_max_retry) begin
            dv_d    = 1'b1;
            ds_d    = RR_LIMIT;
            state_d = S_IDLE;
          end else if (below) begin
            dv_d    = 1'b1;
            ds_d    = RR_FLOOR;
            state_d = S_IDLE;
          end else begin
            code_d    = nxt_code;
            retries_d = retries_q + 1'b1;
            state_d   = S_ISSUE;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      code_q       <= '1;
      retries_q    <= '0;
      blk_q        <= '0;
      msb_q        <= 1'b0;
      done_valid   <= 1'b0;
      ds_q         <= RR_OK;
      done_retries <= '0;
    end else begin
      state_q    <= state_d;
      done_valid <= dv_d;
      code_q     <= code_d;
      retries_q  <= retries_d;
      if (load_en) begin
        blk_q <= req_block;
        msb_q <= req_msb;
      end
      if (dv_d) begin
        ds_q         <= ds_d;
        done_retries <= retries_q;
      end
    end
  end

  assign req_ready   = (state_q == S_IDLE);
  assign rd_valid    = (state_q == S_ISSUE);
  assign done_status = ds_q;

  // R3: a retry always lowers the code
  p_code_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && ecc_valid && !ecc_pass && state_d == S_ISSUE)
      |=> (code_q < $past(code_q)));

  // R7: reported retries never exceed the limit
  p_retry_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_retries <= cfg_max_retry));

  // R6: failed sequences leave the table untouched
  p_fail_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && ds_q != RR_OK) |-> $past(!tbl_wr_en));

  // R4: the result is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);
endmodule

// File: rtl/rretry_ctrl.sv
module rretry_ctrl #(
  parameter int  DEPTH = 64,
  parameter int  CW    = 8,
  parameter int  RC_W  = 4,
  localparam int BW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [BW-1:0]   req_block,
  input  logic            req_msb,
  input  logic            req_relearn,
  input  logic [CW-1:0]   cfg_step_lo,
  input  logic [CW-1:0]   cfg_step_hi,
  input  logic [CW-1:0]   cfg_floor,
  input  logic [RC_W-1:0] cfg_max_retry,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [CW-1:0]   rd_code,
  output logic            rd_msb,
  input  logic            ecc_valid,
  input  logic            ecc_pass,
  output logic            done_valid,
  output logic [1:0]      done_status,
  output logic [RC_W-1:0] done_retries
);
  logic [CW-1:0] tbl_code, code_q, nxt_code, step_sel;
  logic          tbl_wr_en, tbl_rl_en, below, msb_q;
  logic [BW-1:0] blk_q;

  assign step_sel = msb_q ? cfg_step_hi : cfg_step_lo;
  assign rd_code  = code_q;
  assign rd_msb   = msb_q;

  rretry_table #(.DEPTH(DEPTH), .CW(CW), .BW(BW)) i_table (
    .clk(clk), .rst_n(rst_n),
    .rd_blk(req_block), .rd_sel(req_msb), .rd_code(tbl_code),
    .wr_en(tbl_wr_en), .wr_blk(blk_q), .wr_sel(msb_q), .wr_code(code_q),
    .rl_en(tbl_rl_en), .rl_blk(req_block)
  );

  rretry_step #(.CW(CW)) i_step (
    .code(code_q), .step(step_sel), .floor_code(cfg_floor),
    .nxt_code(nxt_code), .below(below)
  );

  rretry_fsm #(.CW(CW), .RC_W(RC_W), .BW(BW)) i_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_block(req_block), .req_msb(req_msb),
    .req_relearn(req_relearn), .req_ready(req_ready),
    .tbl_code(tbl_code), .tbl_wr_en(tbl_wr_en), .tbl_rl_en(tbl_rl_en),
    .blk_q(blk_q), .msb_q(msb_q), .code_q(code_q),
    .nxt_code(nxt_code), .below(below), .cfg_max_retry(cfg_max_retry),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .ecc_valid(ecc_valid), .ecc_pass(ecc_pass),
    .done_valid(done_valid), .done_status(done_status),
    .done_retries(done_retries)
  );

  // R9: a pending command holds its code until taken
  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_code)));

  // R9: no new request is taken while a command is out
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rd_valid);
endmodule

// File: tb/test_rretry_ctrl.sv
module test_rretry_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int CW = 8;
  localparam int RC_W = 3;
  localparam int BW = $clog2(DEPTH);

  logic clk, rst_n;
  logic req_valid, req_ready, req_msb, req_relearn;
  logic [BW-1:0] req_block;
  logic [CW-1:0] cfg_step_lo, cfg_step_hi, cfg_floor;
  logic [RC_W-1:0] cfg_max_retry;
  logic rd_valid, rd_ready, rd_msb;
  logic [CW-1:0] rd_code;
  logic ecc_valid, ecc_pass;
  logic done_valid;
  logic [1:0] done_status;
  logic [RC_W-1:0] done_retries;

  rretry_ctrl #(.DEPTH(DEPTH), .CW(CW), .RC_W(RC_W)) i_rretry_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_block(req_block),
    .req_msb(req_msb), .req_relearn(req_relearn),
    .cfg_step_lo(cfg_step_lo), .cfg_step_hi(cfg_step_hi),
    .cfg_floor(cfg_floor), .cfg_max_retry(cfg_max_retry),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_code(rd_code),
    .rd_msb(rd_msb), .ecc_valid(ecc_valid), .ecc_pass(ecc_pass),
    .done_valid(done_valid), .done_status(done_status),
    .done_retries(done_retries)
  );

  int checks = 0, fails = 0;
  int n_reads = 0, n_done = 0, cycles = 0;
  int mdl_lo[DEPTH], mdl_hi[DEPTH];
  int q_status[$], q_retries[$];
  string q_tag[$];
  int eng_exp, eng_thr, eng_stall;
  bit cur_msb;
  string cur_tag;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // monitor: compare results against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done_valid) begin
      n_done++;
      if (q_status.size() == 0) begin
        check("R8/R9 unexpected result", 1, 0);
      end else begin
        check({q_tag[0], " status"}, int'(done_status), q_status[0]);
        check({q_tag[0], " retries"}, int'(done_retries), q_retries[0]);
        void'(q_status.pop_front());
        void'(q_retries.pop_front());
        void'(q_tag.pop_front());
      end
    end
  end

  // flash engine model
  initial begin
    rd_ready = 1'b0; ecc_valid = 1'b0; ecc_pass = 1'b0;
    eng_stall = 0;
    forever begin
      @(negedge clk);
      if (rst_n && rd_valid) begin
        check({cur_tag, " R2/R3 code"}, int'(rd_code), eng_exp);
        check({cur_tag, " R2 page type"}, int'(rd_msb), int'(cur_msb));
        for (int i = 0; i < eng_stall; i++) begin
          @(negedge clk);
          check("R9 held valid", int'(rd_valid), 1);
          check("R9 held code", int'(rd_code), eng_exp);
        end
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
        @(negedge clk);
        ecc_pass = (eng_exp <= eng_thr);
        ecc_valid = 1'b1;
        @(negedge clk);
        ecc_valid = 1'b0;
        n_reads++;
        eng_exp = eng_exp - int'(cur_msb ? cfg_step_hi : cfg_step_lo);
      end
    end
  end

  task automatic do_read(input int blk, input bit msb, input int thr, input string tag);
    int code, step, r, st;
    code = msb ? mdl_hi[blk] : mdl_lo[blk];
    step = msb ? int'(cfg_step_hi) : int'(cfg_step_lo);
    r = 0;
    eng_exp = code;
    forever begin
      if (code <= thr) begin
        st = 0;
        if (msb) mdl_hi[blk] = code; else mdl_lo[blk] = code;
        break;
      end else if (r == int'(cfg_max_retry)) begin
        st = 2; break;
      end else if (code < step || code - step < int'(cfg_floor)) begin
        st = 1; break;
      end
      code = code - step;
      r++;
    end
    q_status.push_back(st);
    q_retries.push_back(r);
    q_tag.push_back(tag);
    eng_thr = thr;
    cur_msb = msb;
    cur_tag = tag;
    @(negedge clk);
    req_valid = 1'b1; req_block = BW'(blk); req_msb = msb; req_relearn = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    wait (q_status.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    int rd0, dn0;
    rst_n = 1'b0;
    req_valid = 1'b0; req_block = '0; req_msb = 1'b0; req_relearn = 1'b0;
    cfg_step_lo = 8'd4; cfg_step_hi = 8'd10; cfg_floor = 8'd0; cfg_max_retry = 3'd5;
    for (int i = 0; i < DEPTH; i++) begin mdl_lo[i] = 255; mdl_hi[i] = 255; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req_ready", int'(req_ready), 1);
    check("R1 rd_valid", int'(rd_valid), 0);
    check("R1 done_valid", int'(done_valid), 0);

    do_read(0, 1'b0, 255, "R1/R4 first read");
    do_read(1, 1'b0, 245, "R3/R4 low retries");
    do_read(1, 1'b0, 255, "R5 write-back low");
    do_read(1, 1'b1, 230, "R3 high step");
    do_read(1, 1'b0, 255, "R5 other field kept");
    do_read(1, 1'b1, 255, "R5 high write-back");
    do_read(0, 1'b1, 255, "R5 other block kept");

    cfg_max_retry = 3'd2;
    do_read(2, 1'b1, 0, "R7 limit");
    cfg_max_retry = 3'd5;
    do_read(2, 1'b1, 255, "R7 entry unchanged");

    cfg_floor = 8'd240; cfg_max_retry = 3'd7;
    do_read(3, 1'b0, 0, "R6 floor");
    do_read(3, 1'b0, 255, "R6 entry unchanged");
    cfg_max_retry = 3'd3;
    do_read(3, 1'b0, 0, "R7 limit before floor");

    cfg_floor = 8'd0; cfg_step_lo = 8'd100; cfg_max_retry = 3'd7;
    do_read(4, 1'b0, 0, "R6 step underflow");
    cfg_step_lo = 8'd4; cfg_max_retry = 3'd5;

    // relearn block 1
    rd0 = n_reads; dn0 = n_done;
    @(negedge clk);
    req_valid = 1'b1; req_block = BW'(1); req_relearn = 1'b1; req_msb = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; req_relearn = 1'b0;
    mdl_lo[1] = 255; mdl_hi[1] = 255;
    repeat (4) @(negedge clk);
    check("R8 no read issued", n_reads, rd0);
    check("R8 no result", n_done, dn0);
    do_read(1, 1'b0, 255, "R8 low reset");
    do_read(1, 1'b1, 255, "R8 high reset");

    // stray verdict while idle
    dn0 = n_done;
    ecc_pass = 1'b0; ecc_valid = 1'b1;
    @(negedge clk);
    ecc_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 stray verdict ignored", n_done, dn0);
    check("R9 still ready", int'(req_ready), 1);
    do_read(0, 1'b0, 255, "R9 table after stray");

    // engine stalls the command
    eng_stall = 3;
    do_read(5, 1'b0, 250, "R9 stalled command");
    eng_stall = 0;

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule